// File: doc/BRIEF.md
# Dual-Mask Interrupt Request Controller

This block gathers level-sensitive interrupt sources from around a chip into one 32-bit raw status word and drives two active-high request lines from it. The normal request (`irq_o`) and the fast request (`fiq_o`) each have their own enable mask. Both masks are applied to the same raw word. Software reaches the block through a small 32-bit register bus: a word offset, a write strobe, write data and combinational read data. Every mask is changed through a pair of locations, one that sets bits and one that clears them, so no read-modify-write is ever needed.

Two raw bits are not taken from the external source vector. Bit 0 is a software latch, which has its own set and clear locations. Bit 26 is the request line of a cascaded secondary controller built the same way. The external sources and the cascade line pass through a two-flop synchronizer before they reach the raw word. A source is cleared by taking it low at its origin, never by a write to this block.

Register offsets (bits [1:0] of the address are ignored):

| Offset | Access | Content |
|--------|--------|---------|
| 0x00 | read | raw AND normal mask |
| 0x04 | read | raw word |
| 0x08 | read / write-1-set | normal mask |
| 0x0C | write-1-clear | normal mask |
| 0x10 | read / write-1-set | soft latch (bit 0) |
| 0x14 | write-1-clear | soft latch (bit 0) |
| 0x20 | read | raw AND fast mask |
| 0x24 | read | raw word |
| 0x28 | read / write-1-set | fast mask |
| 0x2C | write-1-clear | fast mask |

Top module: `dual_intc`

## Requirements
- R1: After reset both enable masks and the soft latch are zero, `irq_o` and `fiq_o` are low, and with all sources low every location reads zero.
- R2: External source bits 1 to 10 and 22 to 25, 27 and 28 appear at the same positions of the raw word (0x04 and 0x24) two rising clock edges after they change, and not after one.
- R3: A write to 0x08 or 0x28 sets every implemented mask bit written as 1, leaves bits written as 0 unchanged, and reading that location returns the current mask.
- R4: A write to 0x0C or 0x2C clears every mask bit written as 1 and leaves bits written as 0 unchanged. Reading these locations returns zero.
- R5: Offset 0x00 reads the raw word ANDed with the normal mask, and 0x20 reads the raw word ANDed with the fast mask.
- R6: `irq_o` is high exactly when the normal gated word is nonzero, and `fiq_o` is high exactly when the fast gated word is nonzero. The two are independent.
- R7: Writing 1 in bit 0 of 0x10 sets the soft latch, and writing 1 in bit 0 of 0x14 clears it. Writing 0 in bit 0 of either location has no effect. 0x10 reads the latch in bit 0, and the latch is raw bit 0.
- R8: Raw bit 26 follows the synchronized cascade input. Source input bits 0 and 26 are ignored.
- R9: Reserved bits [31:29] and [21:11] always read zero, and writes cannot set them.
- R10: Unmapped offsets read zero. Writes to read-only or unmapped offsets change no state.
- R11: Taking a source low clears its raw bit, and any request it caused, two edges later, without any write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_i | input | 32 | Level-sensitive external sources |
| cascade_i | input | 1 | Request from the secondary controller |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A register write takes effect at the rising edge on which the strobe is sampled. It is visible on read data and on both request lines one cycle later. A source or cascade change needs two rising edges before it shows in the raw word, the gated words and the request lines. The bench drives all inputs on falling edges and reads half a cycle later. It waits exactly one falling edge after each write and exactly two after each source change. One check deliberately reads after a single edge to confirm that the raw word still holds its old value.

// File: rtl/dual_intc_pkg.sv
package dual_intc_pkg;
    localparam int DATA_W      = 32;
    localparam int SYNC_STAGES = 2;
    localparam int SOFT_BIT    = 0;
    localparam int CASCADE_BIT = 26;

    // Raw-word bits fed by external source pins.
    localparam logic [DATA_W-1:0] EXT_MASK  = 32'h1BC0_07FE;
    // Every implemented raw / enable bit.
    localparam logic [DATA_W-1:0] IMPL_MASK = EXT_MASK
                                             | (32'h1 << CASCADE_BIT)
                                             | (32'h1 << SOFT_BIT);

    typedef enum logic [3:0] {
        WO_IRQ_GATED = 4'd0,
        WO_IRQ_RAW   = 4'd1,
        WO_IRQ_ESET  = 4'd2,
        WO_IRQ_ECLR  = 4'd3,
        WO_SOFT_SET  = 4'd4,
        WO_SOFT_CLR  = 4'd5,
        WO_FIQ_GATED = 4'd8,
        WO_FIQ_RAW   = 4'd9,
        WO_FIQ_ESET  = 4'd10,
        WO_FIQ_ECLR  = 4'd11
    } word_off_e;
endpackage

// File: rtl/dual_intc_sync.sv
module dual_intc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dual_intc_mask_reg.sv
module dual_intc_mask_reg #(
    parameter int           W    = 32,
    parameter logic [W-1:0] KEEP = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    logic [W-1:0] hit;
    assign hit = wdata & KEEP;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= '0;
        else if (set_we) q <= q | hit;
        else if (clr_we) q <= q & ~hit;
    end

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((q & $past(hit)) == $past(hit)));                  // R3
    AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> (($past(q) & ~q) == '0));                           // R3
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((q & $past(hit)) == '0));                          // R4
    AST_CLR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((q & ~$past(q)) == '0));                           // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> $stable(q));                          // R10
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({set_we, clr_we}) <= 1);                            // R10
endmodule

// File: rtl/dual_intc.sv
module dual_intc
    import dual_intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] src_i,
    input  logic              cascade_i,
    output logic              irq_o,
    output logic              fiq_o
);
    logic [3:0]        word;
    logic              irq_set, irq_clr, fiq_set, fiq_clr, soft_set, soft_clr;
    logic [DATA_W-1:0] src_s, irq_mask, fiq_mask, raw, irq_gated, fiq_gated;
    logic              casc_s, soft_q;

    assign word = bus_addr[5:2];

    // Write decode: one strobe per set/clear location.
    always_comb begin
        {irq_set, irq_clr, fiq_set, fiq_clr, soft_set, soft_clr} = '0;
        if (bus_we) begin
            unique case (word)
                WO_IRQ_ESET: irq_set  = 1'b1;
                WO_IRQ_ECLR: irq_clr  = 1'b1;
                WO_FIQ_ESET: fiq_set  = 1'b1;
                WO_FIQ_ECLR: fiq_clr  = 1'b1;
                WO_SOFT_SET: soft_set = 1'b1;
                WO_SOFT_CLR: soft_clr = 1'b1;
                default: ;
            endcase
        end
    end

    dual_intc_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_src_sync (
        .clk(clk), .rst_n(rst_n), .d(src_i & EXT_MASK), .q(src_s));

    dual_intc_sync #(.W(1), .STAGES(SYNC_STAGES)) u_casc_sync (
        .clk(clk), .rst_n(rst_n), .d(cascade_i), .q(casc_s));

    dual_intc_mask_reg #(.W(DATA_W), .KEEP(IMPL_MASK)) u_irq_mask (
        .clk(clk), .rst_n(rst_n), .set_we(irq_set), .clr_we(irq_clr),
        .wdata(bus_wdata), .q(irq_mask));

    dual_intc_mask_reg #(.W(DATA_W), .KEEP(IMPL_MASK)) u_fiq_mask (
        .clk(clk), .rst_n(rst_n), .set_we(fiq_set), .clr_we(fiq_clr),
        .wdata(bus_wdata), .q(fiq_mask));

    // Soft latch: a one-bit instance of the same set/clear register (R7).
    dual_intc_mask_reg #(.W(1), .KEEP(1'b1)) u_soft (
        .clk(clk), .rst_n(rst_n), .set_we(soft_set), .clr_we(soft_clr),
        .wdata(bus_wdata[SOFT_BIT]), .q(soft_q));

    always_comb begin
        raw = src_s;
        raw[CASCADE_BIT] = casc_s;
        raw[SOFT_BIT]    = soft_q;
    end

    assign irq_gated = raw & irq_mask;
    assign fiq_gated = raw & fiq_mask;
    assign irq_o     = |irq_gated;
    assign fiq_o     = |fiq_gated;

    always_comb begin
        unique case (word)
            WO_IRQ_GATED: bus_rdata = irq_gated;
            WO_IRQ_RAW,
            WO_FIQ_RAW:   bus_rdata = raw;
            WO_IRQ_ESET:  bus_rdata = irq_mask;
            WO_SOFT_SET:  bus_rdata = {{(DATA_W-1){1'b0}}, soft_q};
            WO_FIQ_GATED: bus_rdata = fiq_gated;
            WO_FIQ_ESET:  bus_rdata = fiq_mask;
            default:      bus_rdata = '0;
        endcase
    end

    AST_RDATA_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~IMPL_MASK) == '0);                               // R9
    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_mask != '0));                                   // R6
    AST_FIQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> (fiq_mask != '0));                                   // R6
    AST_REQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || fiq_o) |-> (raw != '0));                             // R11
    AST_SOFT_IN_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        soft_set && bus_wdata[SOFT_BIT] |=> raw[SOFT_BIT]);            // R7
endmodule

// File: tb/dual_intc_bench.sv
module dual_intc_bench;
    import dual_intc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata, bus_rdata, src_i;
    logic        cascade_i, irq_o, fiq_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0] m_irq, m_fiq, m_src;
    logic        m_soft, m_casc;

    always #10 clk = ~clk;

    dual_intc u_dual_intc (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_i(src_i),
        .cascade_i(cascade_i), .irq_o(irq_o), .fiq_o(fiq_o));

    function automatic logic [31:0] m_raw();
        return (m_src & 32'h1BC0_07FE) | (32'(m_casc) << 26) | 32'(m_soft);
    endfunction

    function automatic logic [31:0] m_read(input int w);
        case (w)
            0:       return m_raw() & m_irq;
            1, 9:    return m_raw();
            2:       return m_irq;
            4:       return 32'(m_soft);
            8:       return m_raw() & m_fiq;
            10:      return m_fiq;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(input int w);
        case (w)
            0, 8:    return "R5";
            1, 9:    return "R2";
            2, 10:   return "R3";
            3, 11:   return "R4";
            4:       return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic rd(input int w, output logic [31:0] d);
        bus_addr = 6'(w << 2);
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input int w, input logic [31:0] d);
        @(negedge clk);
        bus_addr = 6'(w << 2); bus_we = 1'b1; bus_wdata = d;
        case (w)
            2:  m_irq = m_irq | (d & 32'h1FC0_07FF);
            3:  m_irq = m_irq & ~d;
            4:  if (d[0]) m_soft = 1'b1;
            5:  if (d[0]) m_soft = 1'b0;
            10: m_fiq = m_fiq | (d & 32'h1FC0_07FF);
            11: m_fiq = m_fiq & ~d;
            default: ;
        endcase
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic drive_src(input logic [31:0] s, input logic c);
        @(negedge clk);
        src_i = s; cascade_i = c; m_src = s; m_casc = c;
        repeat (2) @(negedge clk);
    endtask

    task automatic check_all();
        logic [31:0] d;
        for (int w = 0; w < 16; w++) begin
            rd(w, d);
            chk(req_of(w), d, m_read(w));
            chk("R9", d & 32'hE03F_F800, 32'h0);
        end
        chk("R6", 32'(irq_o), 32'(|(m_raw() & m_irq)));
        chk("R6", 32'(fiq_o), 32'(|(m_raw() & m_fiq)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
        src_i = '0; cascade_i = 1'b0;
        m_irq = '0; m_fiq = '0; m_src = '0; m_soft = 1'b0; m_casc = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int w = 0; w < 16; w++) begin
            rd(w, d);
            chk("R1", d, 32'h0);
        end
        chk("R1", {30'h0, irq_o, fiq_o}, 32'h0);

        // R2 / R8: walk one source bit at a time, including ignored pins 0 and 26
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            src_i = 32'h1 << i;
            @(negedge clk);
            rd(1, d);
            chk("R2", d, m_raw());              // one edge: still the old value
            m_src = 32'h1 << i;
            @(negedge clk);
            rd(1, d);
            chk("R2", d, m_raw());
            rd(9, d);
            chk("R8", d, m_raw());
        end
        drive_src(32'h0, 1'b1);
        rd(1, d);
        chk("R8", d, 32'h0400_0000);
        drive_src(32'h0, 1'b0);

        // R3 / R4 / R9: all-ones into set locations fills implemented bits only
        wr(2, 32'hFFFF_FFFF);
        wr(10, 32'hFFFF_FFFF);
        rd(2, d);  chk("R9", d, 32'h1FC0_07FF);
        rd(10, d); chk("R9", d, 32'h1FC0_07FF);
        wr(3, 32'hFFFF_FFFF);
        wr(11, 32'hFFFF_FFFF);
        check_all();

        // R7: soft latch set / clear, zero writes ignored
        wr(4, 32'hFFFF_FFFE); check_all();
        wr(4, 32'h1);         check_all();
        wr(5, 32'hFFFF_FFFE); check_all();
        wr(2, 32'h1);         check_all();
        wr(5, 32'h1);         check_all();
        wr(3, 32'h1);

        // R3 / R4 / R5 / R6: mask patterns against several source patterns
        for (int p = 0; p < 6; p++) begin
            drive_src((32'hA5C3_5A3C << p) ^ (32'h1 << (p * 5)), p[0]);
            if (p[1]) wr(4, 32'h1); else wr(5, 32'h1);
            for (int k = 0; k < 8; k++) begin
                logic [31:0] r;
                r = $urandom();
                case (k % 4)
                    0: wr(2, r);
                    1: wr(11, r);
                    2: wr(10, r);
                    default: wr(3, r);
                endcase
                check_all();
            end
        end

        // R6: one single bit enabled on only one side
        drive_src(32'h0000_0020, 1'b0);
        wr(3, 32'hFFFF_FFFF); wr(11, 32'hFFFF_FFFF); wr(5, 32'h1);
        wr(10, 32'h0000_0020);
        chk("R6", {30'h0, irq_o, fiq_o}, 32'h1);
        wr(2, 32'h0000_0020);
        chk("R6", {30'h0, irq_o, fiq_o}, 32'h3);
        check_all();

        // R11: dropping the source clears the request with no write
        drive_src(32'h0, 1'b0);
        chk("R11", {30'h0, irq_o, fiq_o}, 32'h0);
        check_all();

        // R10: writes to read-only and unmapped offsets leave state alone
        wr(2, 32'h1234_5678); wr(10, 32'h0F0F_0F0F); wr(4, 32'h1);
        for (int w = 0; w < 16; w++) begin
            if (w != 2 && w != 3 && w != 4 && w != 5 && w != 10 && w != 11) begin
                wr(w, 32'hFFFF_FFFF);
                check_all();
            end
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule